// File: doc/BRIEF.md
# Blanking-Window Framebuffer Write Arbiter

This block lets a host change pixels in a framebuffer that sits in a single SRAM while the raster keeps scanning it. Display reads and host updates share one memory bus. The display is never switched off, so host writes can only use the idle bus time inside horizontal and vertical blanking.

The host posts writes, each an address and a data word, through a valid/ready handshake. They wait in a small in-order queue. The arbiter starts a queued write only when two conditions hold: the raster is blanking, and the blanking cycles still left cover the full write length. A write that does not fit waits for a later window. Any subset of addresses may be written, so partial frame updates need no full redraw.

Outside write slots the SRAM is held in read mode. Its address is the display address from the timing generator. All SRAM outputs are registered. The SRAM port therefore shows the effect of the timing inputs sampled at the previous clock edge, and the timing generator plans for that one-clock lag.

Top module: `fbwr_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `sram_we` is 0, `sram_oe` is 1, `host_ready` is 1 and `wr_count` is 0.
- R2: In every SRAM slot that is not a write slot, `sram_we` is 0, `sram_oe` is 1 and `sram_addr` equals the `disp_addr` sampled at the edge that opened the slot. No write slot ever corresponds to a sample where `raster_blank` is 0.
- R3: A queued write starts at an edge where `raster_blank` is 1 and `blank_left` (blanking slots left, counting the current one) is at least `WR_CYC`. Its slots then line up with that sample and the following `WR_CYC-1` samples. With `blank_left` exactly `WR_CYC`, the write still starts.
- R4: Each write holds `sram_we` at 1 and `sram_oe` at 0 for exactly `WR_CYC` consecutive slots, with `sram_addr` and `sram_wdata` stable throughout.
- R5: If the blanking slots left are fewer than `WR_CYC`, no write starts, and the request stays queued for a later window.
- R6: The queue holds `FIFO_DEPTH` requests. `host_ready` is 0 exactly when the queue is full, and a request is taken at an edge where both `host_valid` and `host_ready` are 1.
- R7: Writes reach the SRAM in the order in which they were accepted.
- R8: `wr_count` rises by one for each completed write. The new value is visible in the slot after the write's last slot.
- R9: Writes to arbitrary addresses, including the lowest, the highest and repeated ones, are all committed. Queued writes run back to back, with no gap, inside one window when they fit.
- R10: A request presented while `host_ready` is 0 is dropped and never appears on the SRAM port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host offers a write request |
| host_ready | output | 1 | Queue has room; low when full |
| host_addr | input | ADDR_W | Framebuffer address of the request |
| host_data | input | DATA_W | Pixel word of the request |
| raster_blank | input | 1 | Raster is in horizontal or vertical blanking |
| blank_left | input | LEFT_W | Blanking slots remaining, current one included |
| disp_addr | input | ADDR_W | Display read address from the scan counters |
| sram_addr | output | ADDR_W | SRAM address (registered) |
| sram_wdata | output | DATA_W | SRAM write data (registered) |
| sram_we | output | 1 | SRAM write enable, active high (registered) |
| sram_oe | output | 1 | SRAM output enable, active high (registered) |
| wr_count | output | CNT_W | Number of completed writes |

## Verification
Suppose the slot counter or the state register goes wrong. A write would then spill over the end of a window, so `sram_we` would be high in a slot tied to an active-video sample, and the run length would differ from `WR_CYC`. Both show at the SRAM pins within one write length.

A broken queue pointer shows as reordered, duplicated or lost addresses in the write log. It also shows as a `host_ready` that drops or returns at the wrong fill level.

A wrong completion counter shows in `wr_count` one slot after the last write slot. That is when the bench compares it with the number of write runs it has seen.

// File: rtl/fbwr_pkg.sv
package fbwr_pkg;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_WRITE = 1'b1
  } eng_state_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fbwr_fifo.sv
module fbwr_fifo #(
  parameter int W     = 28,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = fbwr_pkg::bits_for(DEPTH);
  localparam int LW = fbwr_pkg::bits_for(DEPTH + 1);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [LW-1:0] level;

  assign full  = (level == FULL_L);
  assign empty = (level == '0);
  assign dout  = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p  <= '0;
      rd_p  <= '0;
      level <= '0;
    end else begin
      if (push) wr_p <= (wr_p == LAST_P) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == LAST_P) ? '0 : rd_p + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_L);

endmodule

// File: rtl/fbwr_engine.sv
module fbwr_engine #(
  parameter int WR_CYC = 3,
  parameter int LEFT_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              have_req,
  input  logic              raster_blank,
  input  logic [LEFT_W-1:0] blank_left,
  output logic              start,
  output logic              write_on,
  output logic [CNT_W-1:0]  done_cnt
);
  import fbwr_pkg::*;

  localparam int CW = bits_for(WR_CYC);
  localparam logic [LEFT_W:0] NEED_L = (LEFT_W + 1)'(WR_CYC);
  localparam logic [CW-1:0]   LOAD_C = CW'(WR_CYC - 1);

  eng_state_e    state;
  logic [CW-1:0] slot;
  logic          finishing, free, fits;

  assign finishing = (state == ENG_WRITE) && (slot == '0);
  assign free      = (state == ENG_IDLE) || finishing;
  assign fits      = raster_blank && ({1'b0, blank_left} >= NEED_L);
  assign start     = free && have_req && fits;
  assign write_on  = start || ((state == ENG_WRITE) && !finishing);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      slot     <= '0;
      done_cnt <= '0;
    end else begin
      if (finishing) done_cnt <= done_cnt + 1'b1;
      if (start) begin
        state <= ENG_WRITE;
        slot  <= LOAD_C;
      end else if (finishing) begin
        state <= ENG_IDLE;
      end else if (state == ENG_WRITE) begin
        slot <= slot - 1'b1;
      end
    end
  end

  // R3
  window_fit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_WRITE && slot != '0) |-> raster_blank);

endmodule

// File: rtl/fbwr_port.sv
module fbwr_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int WR_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              write_on,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_we,
  output logic              sram_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_we    <= 1'b0;
      sram_oe    <= 1'b1;
    end else begin
      sram_we <= write_on;
      sram_oe <= !write_on;
      if (start) begin
        sram_addr  <= req_addr;
        sram_wdata <= req_data;
      end else if (!write_on) begin
        sram_addr <= disp_addr;
      end
    end
  end

  logic        armed;
  logic [15:0] run_len;
  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      run_len <= '0;
    end else begin
      armed   <= 1'b1;
      run_len <= sram_we ? run_len + 1'b1 : '0;
    end
  end

  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (sram_we && $past(sram_we) && !$past(start)) |->
      ($stable(sram_addr) && $stable(sram_wdata)));

  // R4
  write_len_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(sram_we) |-> (run_len != '0 && (32'(run_len) % WR_CYC) == 0));

endmodule

// File: rtl/fbwr_arb.sv
module fbwr_arb #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int WR_CYC     = 3,
  parameter int LEFT_W     = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              raster_blank,
  input  logic [LEFT_W-1:0] blank_left,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_we,
  output logic              sram_oe,
  output logic [CNT_W-1:0]  wr_count
);
  localparam int REQ_W = ADDR_W + DATA_W;

  logic             q_full, q_empty, push, start, write_on;
  logic [REQ_W-1:0] q_head;

  assign host_ready = !q_full;
  assign push       = host_valid && host_ready;

  fbwr_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   ({host_addr, host_data}),
    .full  (q_full),
    .pop   (start),
    .dout  (q_head),
    .empty (q_empty)
  );

  fbwr_engine #(.WR_CYC(WR_CYC), .LEFT_W(LEFT_W), .CNT_W(CNT_W)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .have_req     (!q_empty),
    .raster_blank (raster_blank),
    .blank_left   (blank_left),
    .start        (start),
    .write_on     (write_on),
    .done_cnt     (wr_count)
  );

  fbwr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC)) u_port (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .write_on   (write_on),
    .req_addr   (q_head[REQ_W-1:DATA_W]),
    .req_data   (q_head[DATA_W-1:0]),
    .disp_addr  (disp_addr),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we    (sram_we),
    .sram_oe    (sram_oe)
  );

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2
  active_read_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(raster_blank) |-> (!sram_we && sram_oe && sram_addr == $past(disp_addr)));

  // R8
  done_step_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(sram_we) |-> (wr_count == $past(wr_count) + 1'b1));

endmodule

// File: tb/fbwr_arb_bench.sv
module fbwr_arb_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int WR_CYC = 3;
  localparam int LEFT_W = 8;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0;
  logic host_ready;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_data = '0;
  logic raster_blank = 1'b0;
  logic [LEFT_W-1:0] blank_left = '0;
  logic [ADDR_W-1:0] disp_addr = '0;
  logic [ADDR_W-1:0] sram_addr;
  logic [DATA_W-1:0] sram_wdata;
  logic sram_we, sram_oe;
  logic [CNT_W-1:0] wr_count;

  fbwr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH),
             .WR_CYC(WR_CYC), .LEFT_W(LEFT_W), .CNT_W(CNT_W)) u_fbwr_arb (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_addr(host_addr), .host_data(host_data), .raster_blank(raster_blank),
    .blank_left(blank_left), .disp_addr(disp_addr), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_we(sram_we), .sram_oe(sram_oe),
    .wr_count(wr_count)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [ADDR_W-1:0] exp_addr [32];
  logic [DATA_W-1:0] exp_data [32];
  logic [ADDR_W-1:0] got_addr [32];
  logic [DATA_W-1:0] got_data [32];
  int n_exp = 0;
  int n_got = 0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // SRAM port monitor, sampled just after each rising edge
  int run = 0;
  bit pend = 1'b0;
  logic [ADDR_W-1:0] run_addr;
  logic [DATA_W-1:0] run_data;
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      if (pend) begin
        chk(wr_count == CNT_W'(n_got), "R8 count after write", int'(wr_count), n_got);
        pend = 1'b0;
      end
      if (sram_we) begin
        chk(raster_blank == 1'b1, "R2 write slot outside blanking", int'(raster_blank), 1);
        chk(sram_oe == 1'b0, "R4 oe low in write", int'(sram_oe), 0);
        if (run == 0) begin
          run_addr = sram_addr;
          run_data = sram_wdata;
        end else begin
          chk(sram_addr == run_addr && sram_wdata == run_data, "R4 stable write",
              int'(sram_addr), int'(run_addr));
        end
        run++;
        if (run == WR_CYC) begin
          if (n_got < 32) begin
            got_addr[n_got] = run_addr;
            got_data[n_got] = run_data;
          end
          n_got++;
          run = 0;
          pend = 1'b1;
        end
      end else begin
        chk(run == 0, "R4 write length", run, WR_CYC);
        run = 0;
        chk(sram_oe == 1'b1 && sram_addr == disp_addr, "R2 read mode",
            int'(sram_addr), int'(disp_addr));
      end
    end
  end

  task automatic drive_active(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raster_blank = 1'b0;
      blank_left   = '0;
      disp_addr    = disp_addr + 1'b1;
    end
  endtask

  task automatic drive_blank(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raster_blank = 1'b1;
      blank_left   = LEFT_W'(n - i);
    end
  endtask

  task automatic push_req(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          output bit acc);
    @(negedge clk);
    host_valid = 1'b1;
    host_addr  = a;
    host_data  = d;
    #1;
    acc = host_ready;
    if (acc) begin
      exp_addr[n_exp] = a;
      exp_data[n_exp] = d;
      n_exp++;
    end
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sram_we == 1'b0 && sram_oe == 1'b1, "R1 sram idle in reset", int'(sram_we), 0);
    chk(host_ready == 1'b1, "R1 ready in reset", int'(host_ready), 1);
    chk(wr_count == '0, "R1 count in reset", int'(wr_count), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(sram_we == 1'b0 && sram_oe == 1'b1 && wr_count == '0, "R1 first cycle",
        int'(sram_we), 0);
    mon_en = 1'b1;
  endtask

  task automatic t_fill();
    bit acc;
    push_req(12'h010, 16'hA001, acc); chk(acc, "R6 accept 1", int'(acc), 1);
    push_req(12'h011, 16'hA002, acc); chk(acc, "R6 accept 2", int'(acc), 1);
    push_req(12'h7F0, 16'hA003, acc); chk(acc, "R6 accept 3", int'(acc), 1);
    push_req(12'h020, 16'hA004, acc); chk(acc, "R6 accept 4", int'(acc), 1);
    push_req(12'h333, 16'hDEAD, acc); chk(!acc, "R10 full rejects", int'(acc), 0);
    chk(host_ready == 1'b0, "R6 ready low when full", int'(host_ready), 0);
    drive_active(20);
    chk(wr_count == 16'd0, "R2 no write in active video", int'(wr_count), 0);
  endtask

  task automatic t_window_two();
    drive_blank(7);
    drive_active(4);
    chk(wr_count == 16'd2, "R9 two back-to-back in 7 slots", int'(wr_count), 2);
    chk(host_ready == 1'b1, "R6 ready back after drain", int'(host_ready), 1);
  endtask

  task automatic t_no_fit();
    drive_blank(2);
    drive_active(3);
    chk(wr_count == 16'd2, "R5 short window no write", int'(wr_count), 2);
  endtask

  task automatic t_exact_fit();
    drive_blank(3);
    drive_active(3);
    chk(wr_count == 16'd3, "R3 exact fit starts", int'(wr_count), 3);
    drive_blank(5);
    drive_active(3);
    chk(wr_count == 16'd4, "R3 single in 5 slots", int'(wr_count), 4);
  endtask

  task automatic t_burst();
    bit acc;
    push_req(12'h000, 16'h0000, acc); chk(acc, "R9 accept low addr", int'(acc), 1);
    push_req(12'hFFF, 16'hFFFF, acc); chk(acc, "R9 accept high addr", int'(acc), 1);
    push_req(12'h155, 16'h5A5A, acc); chk(acc, "R9 accept mid", int'(acc), 1);
    push_req(12'h155, 16'hA5A5, acc); chk(acc, "R9 accept repeat", int'(acc), 1);
    drive_blank(12);
    drive_active(3);
    chk(wr_count == 16'd8, "R9 four writes in 12 slots", int'(wr_count), 8);
  endtask

  task automatic t_order();
    chk(n_got == n_exp, "R7 write total", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_addr[i] == exp_addr[i], "R7 address order", int'(got_addr[i]), int'(exp_addr[i]));
      chk(got_data[i] == exp_data[i], "R10 data order", int'(got_data[i]), int'(exp_data[i]));
    end
  endtask

  initial begin
    t_reset();
    t_fill();
    t_window_two();
    t_no_fit();
    t_exact_fit();
    t_burst();
    t_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule